// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Tag Wakeup

This block buffers instructions that have already been renamed to physical register tags and hands them, one per cycle, to a single ALU once their operands exist. Each slot keeps an opcode, a destination tag, two source tags each with its own ready flag, and an age stamp that orders the instruction in the program. Completing instructions announce their destination tag on one or more result-tag buses. Every slot compares those tags with its waiting sources and marks the matching ones ready. Among the slots that are fully ready, the oldest one is sent out. Program order among the others does not matter.

A dispatch port writes one instruction per cycle into any free slot. A source whose value already exists can be flagged ready at that point. An instruction with only one source flags its second source ready. When a branch turns out to be mispredicted, a flush request carrying the branch's age removes every slot that is strictly younger than that age. Ages are compared modulo 2^AGE_W. The ages held in flight at any time must span less than half that range.

Top module: `iq_wakeup_queue`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `iss_valid` is 0 and `disp_full` is 0.
- R2: An instruction accepted at a clock edge with both ready flags set at dispatch appears on the `iss_*` outputs after the next clock edge. It appears there for exactly one cycle, with the opcode, destination, sources and age it was dispatched with.
- R3: A valid broadcast on any result bus whose tag equals a waiting source tag makes that source ready at that clock edge. A tag that matches no waiting source leaves the instruction waiting. An instruction whose sources were both not ready at dispatch issues after the edge that follows the broadcast edge that readies its last waiting source.
- R4: A broadcast made in the same cycle as the dispatch of an instruction that names that tag as a source makes the new entry ready. It then issues after the next edge.
- R5: When several entries are ready, the one with the oldest age issues first. The others follow oldest first, one per cycle.
- R6: A ready entry issues even while an older entry still waits for an operand.
- R7: `disp_full` is 1 when all DEPTH slots are valid and none is issuing in the current cycle. A dispatch offered while `disp_full` is 1 is dropped.
- R8: When every slot is valid and one of them is issuing in the current cycle, `disp_full` is 0. A dispatch in that cycle is accepted into the slot that is being freed.
- R9: A flush request removes every entry whose age is strictly younger than `flush_age`. Entries of equal or older age are kept. A dispatch in the same cycle whose age is younger than `flush_age` is dropped. No entry that is being flushed issues.
- R10: At most one instruction issues per cycle, and `iss_valid` is 0 in any cycle that follows an edge at which no entry was ready.
- R11: Ages compare with wrap-around. Age a is younger than age b when (a − b) mod 2^AGE_W is non-zero and below 2^(AGE_W−1). For example, with AGE_W = 6, age 1 is younger than age 62.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_dst | input | TAG_W | Destination physical tag |
| disp_src0 | input | TAG_W | First source physical tag |
| disp_src0_rdy | input | 1 | First source already available |
| disp_src1 | input | TAG_W | Second source physical tag |
| disp_src1_rdy | input | 1 | Second source already available (set for single-source ops) |
| disp_age | input | AGE_W | Program-order age stamp |
| disp_full | output | 1 | No slot can accept a dispatch this cycle |
| wb_valid | input | NUM_WB | Per-bus broadcast valid |
| wb_tag | input | NUM_WB*TAG_W | Broadcast tags, bus j in bits [j*TAG_W +: TAG_W] |
| flush_valid | input | 1 | Flush request |
| flush_age | input | AGE_W | Age boundary; strictly younger entries are removed |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_op | output | OP_W | Issued opcode |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_src0 | output | TAG_W | Issued first source tag |
| iss_src1 | output | TAG_W | Issued second source tag |
| iss_age | output | AGE_W | Issued age stamp |

## Verification
Every result here is due a fixed number of edges after its stimulus. A dispatch or broadcast changes slot state at its own edge, and the registered issue output shows the effect one edge later. `disp_full` is combinational from slot state and therefore changes right after the edge that fills or readies the last slot. The bench drives inputs and samples outputs one time unit after each rising edge. Each check is placed at the edge count derived from this two-stage path, and a test that expects nothing to issue samples every cycle in which a wrong entry could have appeared.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam int TAG_W = 6;
    localparam int OP_W  = 4;
    localparam int AGE_W = 6;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [OP_W-1:0]  op_t;
    typedef logic [AGE_W-1:0] age_t;

    typedef struct packed {
        op_t  op;
        tag_t dst;
        tag_t src0;
        logic rdy0;
        tag_t src1;
        logic rdy1;
        age_t age;
    } uop_t;

    // a is younger than b when the modular distance a-b lies in the lower half
    function automatic logic is_younger(age_t a, age_t b);
        age_t d;
        d = a - b;
        return (d != '0) && !d[AGE_W-1];
    endfunction

endpackage

// File: rtl/iq_entry.sv
module iq_entry
    import iq_pkg::*;
#(
    parameter int NUM_WB = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  uop_t                    wr_uop,
    input  logic [NUM_WB-1:0]       wb_valid,
    input  tag_t [NUM_WB-1:0]       wb_tags,
    input  logic                    clr,
    output logic                    valid,
    output uop_t                    uop,
    output logic                    ready
);

    function automatic logic tag_hit(tag_t t, logic [NUM_WB-1:0] v, tag_t [NUM_WB-1:0] tags);
        logic h;
        h = 1'b0;
        for (int j = 0; j < NUM_WB; j++) begin
            if (v[j] && tags[j] == t) h = 1'b1;
        end
        return h;
    endfunction

    logic hit0_new, hit1_new, hit0_old, hit1_old;

    always_comb begin
        hit0_new = tag_hit(wr_uop.src0, wb_valid, wb_tags);
        hit1_new = tag_hit(wr_uop.src1, wb_valid, wb_tags);
        hit0_old = tag_hit(uop.src0, wb_valid, wb_tags);
        hit1_old = tag_hit(uop.src1, wb_valid, wb_tags);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            uop   <= '0;
        end else if (wr_en) begin
            valid     <= 1'b1;
            uop       <= wr_uop;
            uop.rdy0  <= wr_uop.rdy0 | hit0_new;
            uop.rdy1  <= wr_uop.rdy1 | hit1_new;
        end else if (clr) begin
            valid <= 1'b0;
        end else if (valid) begin
            if (hit0_old) uop.rdy0 <= 1'b1;
            if (hit1_old) uop.rdy1 <= 1'b1;
        end
    end

    assign ready = valid && uop.rdy0 && uop.rdy1;

    // R3
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && uop.rdy0 && !wr_en && !clr) |=> (valid && uop.rdy0));

endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] free_vec,
    output logic [DEPTH-1:0] slot,
    output logic             any_free
);

    always_comb begin
        slot     = '0;
        any_free = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (free_vec[i] && !any_free) begin
                slot[i]  = 1'b1;
                any_free = 1'b1;
            end
        end
    end

endmodule

// File: rtl/iq_select.sv
module iq_select
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] cand,
    input  age_t [DEPTH-1:0] ages,
    output logic [DEPTH-1:0] grant,
    output logic [IDX_W-1:0] sel_idx,
    output logic             any
);

    age_t best_age;

    always_comb begin
        any      = 1'b0;
        sel_idx  = '0;
        best_age = '0;
        grant    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cand[i] && (!any || is_younger(best_age, ages[i]))) begin
                any      = 1'b1;
                sel_idx  = IDX_W'(i);
                best_age = ages[i];
            end
        end
        if (any) grant[sel_idx] = 1'b1;
    end

endmodule

// File: rtl/iq_wakeup_queue.sv
module iq_wakeup_queue
    import iq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int NUM_WB = 2,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    disp_valid,
    input  logic [OP_W-1:0]         disp_op,
    input  logic [TAG_W-1:0]        disp_dst,
    input  logic [TAG_W-1:0]        disp_src0,
    input  logic                    disp_src0_rdy,
    input  logic [TAG_W-1:0]        disp_src1,
    input  logic                    disp_src1_rdy,
    input  logic [AGE_W-1:0]        disp_age,
    output logic                    disp_full,
    input  logic [NUM_WB-1:0]       wb_valid,
    input  logic [NUM_WB*TAG_W-1:0] wb_tag,
    input  logic                    flush_valid,
    input  logic [AGE_W-1:0]        flush_age,
    output logic                    iss_valid,
    output logic [OP_W-1:0]         iss_op,
    output logic [TAG_W-1:0]        iss_dst,
    output logic [TAG_W-1:0]        iss_src0,
    output logic [TAG_W-1:0]        iss_src1,
    output logic [AGE_W-1:0]        iss_age
);

    tag_t [NUM_WB-1:0] wb_tags;
    uop_t              new_uop;
    uop_t              ent [DEPTH];
    age_t [DEPTH-1:0]  ages;
    logic [DEPTH-1:0]  vld, rdy, kill, cand, grant, slot, wr_vec;
    logic [IDX_W-1:0]  sel_idx;
    logic              any_ready, any_free, disp_killed, disp_take;

    assign wb_tags = wb_tag;

    always_comb begin
        new_uop.op   = disp_op;
        new_uop.dst  = disp_dst;
        new_uop.src0 = disp_src0;
        new_uop.rdy0 = disp_src0_rdy;
        new_uop.src1 = disp_src1;
        new_uop.rdy1 = disp_src1_rdy;
        new_uop.age  = disp_age;
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_ent
            assign ages[g] = ent[g].age;
            assign kill[g] = flush_valid && vld[g] && is_younger(ent[g].age, flush_age);
            assign cand[g] = rdy[g] && !kill[g];
            assign wr_vec[g] = disp_take && slot[g];

            iq_entry #(.NUM_WB(NUM_WB)) u_ent (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (wr_vec[g]),
                .wr_uop   (new_uop),
                .wb_valid (wb_valid),
                .wb_tags  (wb_tags),
                .clr      (grant[g] | kill[g]),
                .valid    (vld[g]),
                .uop      (ent[g]),
                .ready    (rdy[g])
            );
        end
    endgenerate

    iq_select #(.DEPTH(DEPTH)) u_sel (
        .cand    (cand),
        .ages    (ages),
        .grant   (grant),
        .sel_idx (sel_idx),
        .any     (any_ready)
    );

    iq_alloc #(.DEPTH(DEPTH)) u_alloc (
        .free_vec (~vld | grant),
        .slot     (slot),
        .any_free (any_free)
    );

    assign disp_full   = !any_free;
    assign disp_killed = flush_valid && is_younger(disp_age, flush_age);
    assign disp_take   = disp_valid && any_free && !disp_killed;

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_valid <= 1'b0;
            iss_op    <= '0;
            iss_dst   <= '0;
            iss_src0  <= '0;
            iss_src1  <= '0;
            iss_age   <= '0;
        end else begin
            iss_valid <= any_ready;
            iss_op    <= ent[sel_idx].op;
            iss_dst   <= ent[sel_idx].dst;
            iss_src0  <= ent[sel_idx].src0;
            iss_src1  <= ent[sel_idx].src1;
            iss_age   <= ent[sel_idx].age;
        end
    end

    // R10
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R2
    grant_ready_chk: assert property (@(posedge clk) disable iff (rst)
        any_ready |-> (vld[sel_idx] && ent[sel_idx].rdy0 && ent[sel_idx].rdy1));

    // R7
    full_all_valid_chk: assert property (@(posedge clk) disable iff (rst)
        disp_full |-> (&vld));

    // R8
    free_on_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (|grant) |-> !disp_full);

    // R9
    no_flushed_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && any_ready) |-> !is_younger(ent[sel_idx].age, flush_age));

endmodule

// File: tb/sim_iq_wakeup_queue.sv
module sim_iq_wakeup_queue;
    import iq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int NUM_WB = 2;

    logic clk = 1'b0;
    logic rst;
    logic disp_valid, disp_src0_rdy, disp_src1_rdy, disp_full;
    logic [OP_W-1:0]  disp_op;
    logic [TAG_W-1:0] disp_dst, disp_src0, disp_src1;
    logic [AGE_W-1:0] disp_age;
    logic [NUM_WB-1:0] wb_valid;
    logic [NUM_WB*TAG_W-1:0] wb_tag;
    logic flush_valid;
    logic [AGE_W-1:0] flush_age;
    logic iss_valid;
    logic [OP_W-1:0]  iss_op;
    logic [TAG_W-1:0] iss_dst, iss_src0, iss_src1;
    logic [AGE_W-1:0] iss_age;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_wakeup_queue #(.DEPTH(DEPTH), .NUM_WB(NUM_WB)) u0 (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_src0(disp_src0), .disp_src0_rdy(disp_src0_rdy),
        .disp_src1(disp_src1), .disp_src1_rdy(disp_src1_rdy),
        .disp_age(disp_age), .disp_full(disp_full),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .flush_valid(flush_valid), .flush_age(flush_age),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_src0(iss_src0), .iss_src1(iss_src1), .iss_age(iss_age)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_iss(string req, bit v, int age);
        check(req, int'(iss_valid), int'(v));
        if (v && iss_valid) check(req, int'(iss_age), age);
    endtask

    task automatic quiet();
        disp_valid = 0; wb_valid = '0; flush_valid = 0;
    endtask

    task automatic set_disp(int dst, int s0, bit r0, int s1, bit r1, int age);
        disp_valid = 1; disp_op = OP_W'(age % 16); disp_dst = TAG_W'(dst);
        disp_src0 = TAG_W'(s0); disp_src0_rdy = r0;
        disp_src1 = TAG_W'(s1); disp_src1_rdy = r1;
        disp_age = AGE_W'(age);
    endtask

    task automatic disp_one(int dst, int s0, bit r0, int s1, bit r1, int age);
        set_disp(dst, s0, r0, s1, r1, age);
        tick();
        quiet();
    endtask

    task automatic bcast(int bus, int tag);
        wb_valid[bus] = 1'b1;
        wb_tag[bus*TAG_W +: TAG_W] = TAG_W'(tag);
        tick();
        quiet();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; quiet();
        disp_op = '0; disp_dst = '0; disp_src0 = '0; disp_src1 = '0;
        disp_src0_rdy = 0; disp_src1_rdy = 0; disp_age = '0;
        wb_tag = '0; flush_age = '0;
        repeat (3) tick();
        check("R1 iss_valid in reset", int'(iss_valid), 0);
        check("R1 disp_full in reset", int'(disp_full), 0);
        rst = 0;
        tick();
        check("R1 iss_valid after reset", int'(iss_valid), 0);
        check("R1 disp_full after reset", int'(disp_full), 0);

        // R2: ready at dispatch
        disp_one(17, 2, 1, 3, 1, 1);
        expect_iss("R2 not yet", 0, 0);
        tick();
        expect_iss("R2 issue", 1, 1);
        check("R2 op", int'(iss_op), 1);
        check("R2 dst", int'(iss_dst), 17);
        check("R2 src0", int'(iss_src0), 2);
        check("R2 src1", int'(iss_src1), 3);
        tick();
        expect_iss("R2 single cycle", 0, 0);

        // R3: wakeup on bus 0, then non-matching tag and bus 1
        disp_one(20, 5, 0, 0, 1, 2);
        tick();
        expect_iss("R3 waiting", 0, 0);
        bcast(0, 5);
        expect_iss("R3 broadcast edge", 0, 0);
        tick();
        expect_iss("R3 woken bus0", 1, 2);
        disp_one(21, 0, 1, 7, 0, 3);
        bcast(0, 6);
        tick();
        expect_iss("R3 non-matching tag", 0, 0);
        bcast(1, 7);
        expect_iss("R3 broadcast edge bus1", 0, 0);
        tick();
        expect_iss("R3 woken bus1", 1, 3);

        // R4: same-cycle broadcast and dispatch
        set_disp(22, 9, 0, 0, 1, 4);
        wb_valid[0] = 1'b1; wb_tag[0 +: TAG_W] = TAG_W'(9);
        tick();
        quiet();
        expect_iss("R4 dispatch edge", 0, 0);
        tick();
        expect_iss("R4 bypassed wakeup", 1, 4);

        // R5: oldest first among ready, one per cycle (R10)
        disp_one(30, 3, 0, 0, 1, 12);
        disp_one(31, 3, 0, 0, 1, 10);
        disp_one(32, 3, 0, 0, 1, 11);
        bcast(1, 3);
        expect_iss("R10 none ready before", 0, 0);
        for (int k = 0; k < 3; k++) begin
            tick();
            expect_iss("R5 oldest order", 1, 10 + k);
        end
        tick();
        expect_iss("R10 drained", 0, 0);

        // R6: younger ready passes older waiting
        disp_one(33, 8, 0, 0, 1, 13);
        disp_one(34, 1, 1, 2, 1, 14);
        expect_iss("R6 not yet", 0, 0);
        tick();
        expect_iss("R6 younger issues first", 1, 14);
        check("R6 dst", int'(iss_dst), 34);
        bcast(0, 8);
        expect_iss("R6 older still waiting", 0, 0);
        tick();
        expect_iss("R6 older issues", 1, 13);

        // R7 / R8: full queue
        for (int k = 0; k < DEPTH; k++) begin
            check("R7 not full while filling", int'(disp_full), 0);
            disp_one(40 + k, 1, 0, 0, 1, 20 + k);
        end
        check("R7 full", int'(disp_full), 1);
        disp_one(50, 0, 1, 0, 1, 30);
        expect_iss("R7 dropped dispatch", 0, 0);
        tick();
        expect_iss("R7 dropped dispatch later", 0, 0);
        check("R7 still full", int'(disp_full), 1);
        bcast(0, 1);
        expect_iss("R8 broadcast edge", 0, 0);
        check("R8 full clears while issuing", int'(disp_full), 0);
        disp_one(51, 0, 1, 0, 1, 28);
        expect_iss("R8 issue during refill", 1, 20);
        for (int k = 1; k < DEPTH; k++) begin
            tick();
            expect_iss("R8 ordered drain", 1, 20 + k);
        end
        tick();
        expect_iss("R8 refilled slot issues", 1, 28);
        tick();
        expect_iss("R8 empty", 0, 0);

        // R9: flush younger than 41 plus same-cycle younger dispatch
        for (int k = 0; k < 4; k++) disp_one(52 + k, 2, 0, 0, 1, 40 + k);
        set_disp(60, 0, 1, 0, 1, 44);
        flush_valid = 1; flush_age = AGE_W'(41);
        tick();
        quiet();
        expect_iss("R9 flush edge", 0, 0);
        bcast(1, 2);
        expect_iss("R9 flushed dispatch absent", 0, 0);
        tick();
        expect_iss("R9 older kept", 1, 40);
        tick();
        expect_iss("R9 boundary kept", 1, 41);
        tick();
        expect_iss("R9 younger removed", 0, 0);
        tick();
        expect_iss("R9 younger removed later", 0, 0);

        // R11: wrap-around ages, 62 older than 1
        disp_one(61, 4, 0, 0, 1, 1);
        disp_one(62, 4, 0, 0, 1, 62);
        bcast(0, 4);
        tick();
        expect_iss("R11 wrapped older first", 1, 62);
        tick();
        expect_iss("R11 wrapped younger second", 1, 1);
        tick();
        expect_iss("R10 idle at end", 0, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule